// File: doc/BRIEF.md
# PCIe Root Port Bring-up Sequencer

This block brings a PCIe root port from power-on to link training without software help. After a start pulse it sets the PHY SRAM bypass control and the root-port device type. It then writes fixed divider settings to the reference-clock PLL and turns that PLL on. It samples the PLL lock flag at a fixed polling interval and stops with an error when a bounded number of samples have all failed. Once the PLL is locked, the block releases the controller core from reset. It keeps the endpoint reset line (PERST#, active low) asserted for a mandated minimum time, releases it, and lets the link settle.

In root-port mode the block keeps LTSSM enable low while it polls the PHY MPLL lock flag under the same interval and limit. It raises LTSSM enable and reports done once MPLL lock is seen. If MPLL lock never arrives, it pulls PERST# low again, holds it for a short interval and then reports an error. In endpoint mode the link-start step is skipped, and LTSSM enable is never driven. All timing is counted in cycles of the 24 MHz auxiliary clock, and every duration is a parameter.

Top module: `pcie_rp_bringup`

## Requirements
- R1: While reset is asserted and afterwards until the first start, every output is low: PERST# asserted, core held in reset, PLL disabled, divider fields zero, LTSSM off, done and error clear, error code 0.
- R2: A start pulse sampled on edge E0 sets SRAM bypass and device type (root-port flag = not endpoint) on edge E1. On E2 it writes the dividers: reference 0, feedback 0x32, both post dividers 2. On E3 it asserts PLL enable with output-enable field 0xC.
- R3: PLL lock is sampled once every POLL_CYC cycles, the first sample POLL_CYC cycles after PLL enable. The core reset is released on the edge that takes the first sample that finds lock.
- R4: If MAX_POLLS consecutive PLL samples find no lock, error is raised with code 1 on the edge of the last sample. PERST# stays asserted and the core stays in reset.
- R5: PERST# is deasserted exactly PERST_HOLD_CYC cycles after the core reset is released. It is never deasserted before the core has been out of reset that long.
- R6: SETTLE_CYC cycles after PERST# is deasserted, the block either starts MPLL polling (root port) or reports done (endpoint).
- R7: In root-port mode, LTSSM enable and done rise together on the edge of the first MPLL sample that finds lock. The MPLL samples are taken every POLL_CYC cycles from the end of the settle time. LTSSM enable is high only while PERST# and the core reset are both released.
- R8: If MAX_POLLS MPLL samples find no lock, PERST# is asserted again on the edge of the last sample. After FAIL_HOLD_CYC more cycles, error rises with code 2.
- R9: In endpoint mode LTSSM enable is never asserted, and the MPLL lock input has no effect on done, error or code.
- R10: A start pulse in any state returns all outputs to their reset values on that edge and begins the sequence again from E0.
- R11: Done and error are never high together. Once set, each holds its value, and the error code's, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz auxiliary clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start / restart pulse |
| ep_mode_i | input | 1 | 1 = endpoint mode, sampled with start |
| pll_lock_i | input | 1 | Reference PLL lock flag |
| mpll_lock_i | input | 1 | PHY MPLL-A lock flag |
| sram_bypass_o | output | 1 | PHY SRAM bypass control |
| rc_mode_o | output | 1 | Device type select, 1 = root port |
| pll_ref_div_o | output | 6 | PLL reference divider |
| pll_fb_div_o | output | 12 | PLL feedback divider |
| pll_post_a_o | output | 3 | PLL first post divider |
| pll_post_b_o | output | 3 | PLL second post divider |
| pll_en_o | output | 1 | PLL enable |
| pll_out_en_o | output | 4 | PLL output enables |
| core_rst_n_o | output | 1 | Controller core reset, active low |
| perst_n_o | output | 1 | Endpoint reset PERST#, active low |
| ltssm_en_o | output | 1 | Link training enable |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Sequence failed |
| err_code_o | output | 2 | 0 none, 1 PLL timeout, 2 MPLL timeout |

## Verification
A wrong state or a miscounted timer shows up at the ports as a shifted edge. The core-reset release, the PERST# rise, the LTSSM rise or the error flag lands one or more cycles early or late. This is visible the first time the affected step runs, within about a hundred cycles under the bench's short timing parameters. The bench therefore records the exact cycle in which each output first changes and compares it with the cycle worked out from the polling interval, the sample limit and the hold lengths. A lost mode bit or a missed restart shows as LTSSM enable in endpoint mode, or as stale flags on the edge after a start.

// File: rtl/brup_pkg.sv
package brup_pkg;

    localparam int REF_DIV_W  = 6;
    localparam int FB_DIV_W   = 12;
    localparam int POST_DIV_W = 3;
    localparam int OUT_EN_W   = 4;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_PLL  = 2'd1;
    localparam logic [1:0] ERR_MPLL = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG,
        ST_PROG,
        ST_PLL_ON,
        ST_PLL_WAIT,
        ST_HOLD,
        ST_SETTLE,
        ST_MPLL_WAIT,
        ST_UP,
        ST_FAIL_HOLD,
        ST_FAULT
    } state_t;

endpackage

// File: rtl/brup_lock_poll.sv
module brup_lock_poll #(
    parameter int POLL_CYC  = 480,
    parameter int MAX_POLLS = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic lock_i,
    output logic hit_o,
    output logic expire_o
);
    localparam int PW = $clog2(POLL_CYC + 1);
    localparam int NW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] TICK_LAST = PW'(POLL_CYC - 1);
    localparam logic [NW-1:0] POLL_LAST = NW'(MAX_POLLS - 1);

    typedef struct packed {
        logic [PW-1:0] tick;
        logic [NW-1:0] polls;
    } poll_t;

    poll_t p_d, p_q;
    logic  sample;

    assign sample   = run_i && (p_q.tick == TICK_LAST);
    assign hit_o    = sample && lock_i;
    assign expire_o = sample && !lock_i && (p_q.polls == POLL_LAST);

    always_comb begin
        p_d = p_q;
        if (!run_i) begin
            p_d = '0;
        end else if (sample) begin
            p_d.tick  = '0;
            p_d.polls = p_q.polls + 1'b1;
        end else begin
            p_d.tick = p_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.tick <= TICK_LAST); // R3
    AST_POLLS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (p_q.polls <= POLL_LAST)); // R4

endmodule

// File: rtl/brup_delay.sv
module brup_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign zero_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)        cnt_d = load_val_i;
        else if (!zero_o)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DELAY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
    import brup_pkg::*;
#(
    parameter int POLL_CYC       = 480,
    parameter int MAX_POLLS      = 25000,
    parameter int PERST_HOLD_CYC = 2400000,
    parameter int SETTLE_CYC     = 24000,
    parameter int FAIL_HOLD_CYC  = 24000,
    parameter logic [5:0]  REF_DIV_VAL = 6'd0,
    parameter logic [11:0] FB_DIV_VAL  = 12'h032,
    parameter logic [2:0]  POST_A_VAL  = 3'd2,
    parameter logic [2:0]  POST_B_VAL  = 3'd2,
    parameter logic [3:0]  OUT_EN_VAL  = 4'hC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ep_mode_i,
    input  logic        pll_lock_i,
    input  logic        mpll_lock_i,
    output logic        sram_bypass_o,
    output logic        rc_mode_o,
    output logic [5:0]  pll_ref_div_o,
    output logic [11:0] pll_fb_div_o,
    output logic [2:0]  pll_post_a_o,
    output logic [2:0]  pll_post_b_o,
    output logic        pll_en_o,
    output logic [3:0]  pll_out_en_o,
    output logic        core_rst_n_o,
    output logic        perst_n_o,
    output logic        ltssm_en_o,
    output logic        done_o,
    output logic        err_o,
    output logic [1:0]  err_code_o
);
    localparam int MAX_AB = (PERST_HOLD_CYC > SETTLE_CYC) ? PERST_HOLD_CYC : SETTLE_CYC;
    localparam int MAX_D  = (MAX_AB > FAIL_HOLD_CYC) ? MAX_AB : FAIL_HOLD_CYC;
    localparam int TW     = $clog2(MAX_D + 1);
    localparam logic [TW-1:0] HOLD_LD   = TW'(PERST_HOLD_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] FAIL_LD   = TW'(FAIL_HOLD_CYC - 1);

    typedef struct packed {
        state_t                  state;
        logic                    ep;
        logic                    sram;
        logic                    rc;
        logic [REF_DIV_W-1:0]    ref_div;
        logic [FB_DIV_W-1:0]     fb_div;
        logic [POST_DIV_W-1:0]   post_a;
        logic [POST_DIV_W-1:0]   post_b;
        logic                    pll_en;
        logic [OUT_EN_W-1:0]     out_en;
        logic                    core_rst_n;
        logic                    perst_n;
        logic                    ltssm;
        logic                    done;
        logic                    err;
        logic [1:0]              code;
    } seq_t;

    seq_t          r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          poll_run, poll_lock, poll_hit, poll_expire;

    assign poll_run  = (r_q.state == ST_PLL_WAIT) || (r_q.state == ST_MPLL_WAIT);
    assign poll_lock = (r_q.state == ST_PLL_WAIT) ? pll_lock_i : mpll_lock_i;

    brup_lock_poll #(
        .POLL_CYC  (POLL_CYC),
        .MAX_POLLS (MAX_POLLS)
    ) poll_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (poll_run),
        .lock_i   (poll_lock),
        .hit_o    (poll_hit),
        .expire_o (poll_expire)
    );

    brup_delay #(
        .W (TW)
    ) delay_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start_i) begin
            r_d       = '0;
            r_d.ep    = ep_mode_i;
            r_d.state = ST_CFG;
        end else begin
            unique case (r_q.state)
                ST_CFG: begin
                    r_d.sram  = 1'b1;
                    r_d.rc    = !r_q.ep;
                    r_d.state = ST_PROG;
                end
                ST_PROG: begin
                    r_d.ref_div = REF_DIV_VAL;
                    r_d.fb_div  = FB_DIV_VAL;
                    r_d.post_a  = POST_A_VAL;
                    r_d.post_b  = POST_B_VAL;
                    r_d.state   = ST_PLL_ON;
                end
                ST_PLL_ON: begin
                    r_d.pll_en = 1'b1;
                    r_d.out_en = OUT_EN_VAL;
                    r_d.state  = ST_PLL_WAIT;
                end
                ST_PLL_WAIT: begin
                    if (poll_hit) begin
                        r_d.core_rst_n = 1'b1;
                        r_d.state      = ST_HOLD;
                        tmr_load       = 1'b1;
                        tmr_val        = HOLD_LD;
                    end else if (poll_expire) begin
                        r_d.err   = 1'b1;
                        r_d.code  = ERR_PLL;
                        r_d.state = ST_FAULT;
                    end
                end
                ST_HOLD: begin
                    if (tmr_zero) begin
                        r_d.perst_n = 1'b1;
                        r_d.state   = ST_SETTLE;
                        tmr_load    = 1'b1;
                        tmr_val     = SETTLE_LD;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        if (r_q.ep) begin
                            r_d.done  = 1'b1;
                            r_d.state = ST_UP;
                        end else begin
                            r_d.state = ST_MPLL_WAIT;
                        end
                    end
                end
                ST_MPLL_WAIT: begin
                    if (poll_hit) begin
                        r_d.ltssm = 1'b1;
                        r_d.done  = 1'b1;
                        r_d.state = ST_UP;
                    end else if (poll_expire) begin
                        r_d.perst_n = 1'b0;
                        r_d.state   = ST_FAIL_HOLD;
                        tmr_load    = 1'b1;
                        tmr_val     = FAIL_LD;
                    end
                end
                ST_FAIL_HOLD: begin
                    if (tmr_zero) begin
                        r_d.err   = 1'b1;
                        r_d.code  = ERR_MPLL;
                        r_d.state = ST_FAULT;
                    end
                end
                default: r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sram_bypass_o = r_q.sram;
    assign rc_mode_o     = r_q.rc;
    assign pll_ref_div_o = r_q.ref_div;
    assign pll_fb_div_o  = r_q.fb_div;
    assign pll_post_a_o  = r_q.post_a;
    assign pll_post_b_o  = r_q.post_b;
    assign pll_en_o      = r_q.pll_en;
    assign pll_out_en_o  = r_q.out_en;
    assign core_rst_n_o  = r_q.core_rst_n;
    assign perst_n_o     = r_q.perst_n;
    assign ltssm_en_o    = r_q.ltssm;
    assign done_o        = r_q.done;
    assign err_o         = r_q.err;
    assign err_code_o    = r_q.code;

    // Cycles the core has been out of reset while PERST# is still asserted.
    localparam int HW = $clog2(PERST_HOLD_CYC + 2);
    logic [HW-1:0] hold_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 hold_seen_q <= '0;
        else if (!(core_rst_n_o && !perst_n_o))     hold_seen_q <= '0;
        else if (hold_seen_q != {HW{1'b1}})         hold_seen_q <= hold_seen_q + 1'b1;
    end

    AST_CFG_BEFORE_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o |-> sram_bypass_o); // R2
    AST_CORE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n_o) |-> $past(pll_lock_i)); // R3
    AST_PLL_TIMEOUT_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == ERR_PLL) |-> (!core_rst_n_o && !perst_n_o)); // R4
    AST_PERST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (hold_seen_q >= HW'(PERST_HOLD_CYC))); // R5
    AST_LTSSM_AFTER_MPLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ltssm_en_o) |-> $past(mpll_lock_i)); // R7
    AST_LTSSM_LINK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en_o |-> (perst_n_o && core_rst_n_o)); // R7
    AST_MPLL_FAIL_PERST: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == ERR_MPLL) |-> !perst_n_o); // R8
    AST_EP_NO_LTSSM: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ep |-> !ltssm_en_o); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R11
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && (done_o || err_o)) |=> ($stable(done_o) && $stable(err_o) && $stable(err_code_o))); // R11

endmodule

// File: tb/pcie_rp_bringup_tb_top.sv
`timescale 1ns/1ps
module pcie_rp_bringup_tb_top;

    localparam int P  = 4;
    localparam int M  = 5;
    localparam int H  = 20;
    localparam int S  = 6;
    localparam int F  = 8;
    localparam int NEVER = 999;
    localparam int NROW  = 9;
    localparam int RUN   = 70;

    // Scenario table: mode, lock timing, expected first-change cycles (-1 = never).
    localparam int V_EP   [NROW] = '{0, 1, 0, 0, 0, 0, 1, 0, 1};
    localparam int V_PLL  [NROW] = '{0, 0, NEVER, 12, 20, 0, 0, 0, NEVER};
    localparam int V_MPLL [NROW] = '{0, 0, 0, 0, 0, NEVER, NEVER, 40, 0};
    localparam int X_PLLEN[NROW] = '{3, 3, 3, 3, 3, 3, 3, 3, 3};
    localparam int X_CORE [NROW] = '{7, 7, -1, 15, 23, 7, 7, 7, -1};
    localparam int X_PERST[NROW] = '{27, 27, -1, 35, 43, 27, 27, 27, -1};
    localparam int X_LTSSM[NROW] = '{37, -1, -1, 45, 53, -1, -1, 41, -1};
    localparam int X_DONE [NROW] = '{37, 33, -1, 45, 53, -1, 33, 41, -1};
    localparam int X_ERR  [NROW] = '{-1, -1, 23, -1, -1, 61, -1, -1, 23};
    localparam int X_CODE [NROW] = '{0, 0, 1, 0, 0, 2, 0, 0, 1};
    localparam int X_PFALL[NROW] = '{-1, -1, -1, -1, -1, 53, -1, -1, -1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ep_mode_i = 1'b0;
    logic pll_lock_i = 1'b0;
    logic mpll_lock_i = 1'b0;
    logic sram_bypass_o, rc_mode_o, pll_en_o, core_rst_n_o, perst_n_o;
    logic ltssm_en_o, done_o, err_o;
    logic [5:0]  pll_ref_div_o;
    logic [11:0] pll_fb_div_o;
    logic [2:0]  pll_post_a_o, pll_post_b_o;
    logic [3:0]  pll_out_en_o;
    logic [1:0]  err_code_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pcie_rp_bringup #(
        .POLL_CYC(P), .MAX_POLLS(M), .PERST_HOLD_CYC(H),
        .SETTLE_CYC(S), .FAIL_HOLD_CYC(F)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ep_mode_i(ep_mode_i),
        .pll_lock_i(pll_lock_i), .mpll_lock_i(mpll_lock_i),
        .sram_bypass_o(sram_bypass_o), .rc_mode_o(rc_mode_o),
        .pll_ref_div_o(pll_ref_div_o), .pll_fb_div_o(pll_fb_div_o),
        .pll_post_a_o(pll_post_a_o), .pll_post_b_o(pll_post_b_o),
        .pll_en_o(pll_en_o), .pll_out_en_o(pll_out_en_o),
        .core_rst_n_o(core_rst_n_o), .perst_n_o(perst_n_o),
        .ltssm_en_o(ltssm_en_o), .done_o(done_o), .err_o(err_o),
        .err_code_o(err_code_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic pll_l, input logic mpll_l);
        @(negedge clk);
        rst_n = 1'b0;
        pll_lock_i = pll_l;
        mpll_lock_i = mpll_l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Start sampled on edge E0; returns half a cycle after E0.
    task automatic pulse_start(input logic ep);
        ep_mode_i = ep;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 perst_n in reset", perst_n_o, 0);
        check("R1 core_rst_n in reset", core_rst_n_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle outputs", {sram_bypass_o, rc_mode_o, pll_en_o, ltssm_en_o, done_o, err_o}, 0);
        check("R1 idle dividers", {pll_ref_div_o, pll_fb_div_o, pll_out_en_o, err_code_o}, 0);

        for (int row = 0; row < NROW; row++) begin
            int t_pllen, t_core, t_perst, t_ltssm, t_done, t_err, t_pfall;
            logic prev_perst;
            t_pllen = -1; t_core = -1; t_perst = -1; t_ltssm = -1;
            t_done = -1; t_err = -1; t_pfall = -1;
            do_reset(V_PLL[row] == 0, V_MPLL[row] == 0);
            pulse_start(V_EP[row] != 0);
            prev_perst = perst_n_o;
            for (int n = 1; n <= RUN; n++) begin
                @(negedge clk);
                if (n == 1) begin
                    check("R2 bypass on E1", sram_bypass_o, 1);
                    check("R2 device type on E1", rc_mode_o, V_EP[row] == 0);
                    check("R2 dividers still clear on E1", pll_fb_div_o, 0);
                end
                if (n == 2 && row == 0) begin
                    check("R2 ref div", pll_ref_div_o, 0);
                    check("R2 fb div", pll_fb_div_o, 'h32);
                    check("R2 post a", pll_post_a_o, 2);
                    check("R2 post b", pll_post_b_o, 2);
                    check("R2 pll off on E2", pll_en_o, 0);
                end
                if (n == 3 && row == 0) check("R2 out enable", pll_out_en_o, 'hC);
                if (pll_en_o && t_pllen < 0) t_pllen = n;
                if (core_rst_n_o && t_core < 0) t_core = n;
                if (perst_n_o && t_perst < 0) t_perst = n;
                if (ltssm_en_o && t_ltssm < 0) t_ltssm = n;
                if (done_o && t_done < 0) t_done = n;
                if (err_o && t_err < 0) t_err = n;
                if (prev_perst && !perst_n_o && t_pfall < 0) t_pfall = n;
                if (done_o && err_o) check("R11 done with error", 1, 0);
                prev_perst = perst_n_o;
                if (n == V_PLL[row]) pll_lock_i = 1'b1;
                if (n == V_MPLL[row]) mpll_lock_i = 1'b1;
            end
            $display("row %0d", row);
            check("R2 pll enable cycle", t_pllen, X_PLLEN[row]);
            check("R3 core release cycle", t_core, X_CORE[row]);
            check("R5 perst release cycle", t_perst, X_PERST[row]);
            check("R7 R9 ltssm cycle", t_ltssm, X_LTSSM[row]);
            check("R6 R7 done cycle", t_done, X_DONE[row]);
            check("R4 R8 error cycle", t_err, X_ERR[row]);
            check("R4 R8 error code", err_code_o, X_CODE[row]);
            check("R8 perst reassert cycle", t_pfall, X_PFALL[row]);
            check("R11 done held", done_o, X_DONE[row] >= 0);
            check("R11 error held", err_o, X_ERR[row] >= 0);
        end

        // R10: restart in the PERST# hold phase
        do_reset(1'b1, 1'b1);
        pulse_start(1'b0);
        repeat (15) @(negedge clk);
        check("R10 core released before restart", core_rst_n_o, 1);
        pulse_start(1'b0);
        check("R10 restart clears core", core_rst_n_o, 0);
        check("R10 restart clears pll and cfg", {pll_en_o, sram_bypass_o, pll_fb_div_o}, 0);
        check("R10 restart perst", perst_n_o, 0);
        repeat (6) @(negedge clk);
        check("R10 core still held at E6", core_rst_n_o, 0);
        @(negedge clk);
        check("R10 core released at E7", core_rst_n_o, 1);

        // R10 R11: restart after a PLL timeout clears the error
        do_reset(1'b0, 1'b0);
        pulse_start(1'b0);
        repeat (30) @(negedge clk);
        check("R4 fault before restart", {err_o, err_code_o}, 3'b101);
        pll_lock_i = 1'b1;
        pulse_start(1'b1);
        check("R10 error cleared", {err_o, err_code_o}, 0);
        repeat (33) @(negedge clk);
        check("R9 ep done after restart", done_o, 1);
        check("R9 ep ltssm after restart", ltssm_en_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule